// File: doc/BRIEF.md
# Direct Local-Memory Operand Fetch

This block supplies a 32-bit source operand that is read straight out of shared local memory, instead of from a register. The block takes a start strobe with a 32-bit control word. The control word carries two things: the byte offset into local memory, and a format code that sets the access size and signedness. The block issues exactly one read to a byte-addressed memory port and waits for the memory's valid response. It then extracts a byte, a halfword or a word, zero- or sign-extends it to 32 bits, and presents the value with a one-cycle done pulse. The caller puts that value in place of the instruction's first source operand.

A single state machine sequences the fetch through four named states:
- `ST_IDLE` waits for a start.
- `ST_ISSUE` drives the memory request for exactly one cycle.
- `ST_WAIT` holds until the memory returns valid data.
- `ST_DONE` pulses done.

The transitions are:
- accept: `ST_IDLE` to `ST_ISSUE`, taken on a start strobe.
- issue: `ST_ISSUE` to `ST_WAIT`, taken unconditionally.
- capture: `ST_WAIT` to `ST_DONE`, taken on memory valid.
- retire: `ST_DONE` to `ST_IDLE`, taken unconditionally.

A start that arrives in any state other than `ST_IDLE` is ignored.

Top module: `lmd_operand_fetch`

## Requirements
- R1: A start in `ST_IDLE` latches the control word. Bits 15:0 are the byte offset and bits 18:16 are the format code. On the following cycle the block raises `mem_req_o` for exactly one cycle, with `mem_addr_o` equal to the offset.
- R2: Each accepted start produces exactly one memory request and exactly one `done_o` pulse, and that pulse lasts one cycle.
- R3: The memory returns `mem_rdata_i[8k+7:8k]` as the byte at address (offset + k) mod 65536, for k = 0..3, with `mem_valid_i` high for one cycle. That response comes no earlier than the cycle after the request. `done_o` rises on the cycle after `mem_valid_i` is seen in `ST_WAIT`.
- R4: Format 0 returns the byte at the offset, zero-extended.
- R5: Format 1 returns the little-endian halfword {byte(offset+1), byte(offset)}, zero-extended.
- R6: Formats 2 and 3 return the little-endian word {byte(offset+3) .. byte(offset)} unchanged.
- R7: Format 4 returns the byte at the offset, sign-extended from its bit 7.
- R8: Format 5 returns the little-endian halfword, sign-extended from its bit 15.
- R9: Formats 6 and 7 behave as format 2.
- R10: A start that arrives while a fetch is in progress (from acceptance through the done cycle) is ignored. It does not change the address, the format, the number of requests or the returned value.
- R11: `result_o` holds its value between done pulses. After reset, `result_o` is 0 and both `done_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for one fetch |
| ctrl_i | input | 32 | Control word: offset in bits 15:0, format code in bits 18:16 |
| mem_req_o | output | 1 | One-cycle read request to local memory |
| mem_addr_o | output | 16 | Byte address of the read |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Four bytes starting at the request address, lowest address in bits 7:0 |
| result_o | output | 32 | Extended operand value |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
Some properties are checked on every cycle by the assertions:
- the request lasts one cycle and done lasts one cycle;
- done always follows a memory valid;
- the latched address stays steady while a fetch is in progress;
- the upper result bits are correct for the zero- and sign-extending byte formats.

Other properties can only be shown by the bench's scenarios:
- the exact value assembled for every format code, including the aliased codes and offsets that wrap past the top of memory;
- that a start arriving mid-fetch leaves the result and the request count untouched.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    localparam int OFFS_W = 16;
    localparam int FMT_W  = 3;
    localparam int WORD_W = 32;

    typedef enum logic [FMT_W-1:0] {
        FMT_U8   = 3'd0,
        FMT_U16  = 3'd1,
        FMT_U32  = 3'd2,
        FMT_U32A = 3'd3,
        FMT_S8   = 3'd4,
        FMT_S16  = 3'd5,
        FMT_U32B = 3'd6,
        FMT_U32C = 3'd7
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } fetch_st_e;

endpackage

// File: rtl/lmd_ctrl_fsm.sv
module lmd_ctrl_fsm
    import lmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mem_valid_i,
    output logic accept_o,
    output logic capture_o,
    output logic mem_req_o,
    output logic done_o,
    output logic busy_o
);

    fetch_st_e state_q;
    fetch_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)     state_d = ST_ISSUE;
            ST_ISSUE:                  state_d = ST_WAIT;
            ST_WAIT:  if (mem_valid_i) state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept_o  = 1'b0;
        capture_o = 1'b0;
        mem_req_o = 1'b0;
        done_o    = 1'b0;
        busy_o    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = start_i;
            end
            ST_ISSUE: mem_req_o = 1'b1;
            ST_WAIT:  capture_o = mem_valid_i;
            ST_DONE:  done_o    = 1'b1;
            default:  busy_o    = 1'b0;
        endcase
    end

    // R1
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    // R2
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_valid_i));

endmodule

// File: rtl/lmd_cmd_reg.sv
module lmd_cmd_reg
    import lmd_pkg::*;
#(
    parameter int CTRL_W = 32,
    parameter int ADDR_W = OFFS_W,
    parameter int FMTW   = FMT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [FMTW-1:0]   fmt_o
);

    localparam int FMT_LSB = ADDR_W;
    localparam int FMT_MSB = ADDR_W + FMTW - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            fmt_o  <= '0;
        end else if (load_i) begin
            addr_o <= ctrl_i[ADDR_W-1:0];
            fmt_o  <= ctrl_i[FMT_MSB:FMT_LSB];
        end
    end

endmodule

// File: rtl/lmd_extract.sv
module lmd_extract
    import lmd_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic [DW-1:0]    raw_i,
    input  logic [FMT_W-1:0] fmt_i,
    output logic [DW-1:0]    value_o
);

    localparam int BYTE_W = 8;
    localparam int HALF_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lane8;
    logic [HALF_W-1:0] lane16;

    assign lane8  = raw_i[BYTE_W-1:0];
    assign lane16 = raw_i[HALF_W-1:0];

    always_comb begin
        unique case (fmt_e'(fmt_i))
            FMT_U8:  value_o = {{(DW-BYTE_W){1'b0}}, lane8};
            FMT_U16: value_o = {{(DW-HALF_W){1'b0}}, lane16};
            FMT_S8:  value_o = {{(DW-BYTE_W){lane8[BYTE_W-1]}}, lane8};
            FMT_S16: value_o = {{(DW-HALF_W){lane16[HALF_W-1]}}, lane16};
            FMT_U32, FMT_U32A, FMT_U32B, FMT_U32C: value_o = raw_i;
            default: value_o = raw_i;
        endcase
    end

endmodule

// File: rtl/lmd_operand_fetch.sv
module lmd_operand_fetch
    import lmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] ctrl_i,
    output logic              mem_req_o,
    output logic [OFFS_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [WORD_W-1:0] result_o,
    output logic              done_o
);

    logic             accept;
    logic             capture;
    logic             busy;
    logic [FMT_W-1:0] fmt_q;
    logic [WORD_W-1:0] ext_val;

    lmd_ctrl_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mem_valid_i (mem_valid_i),
        .accept_o    (accept),
        .capture_o   (capture),
        .mem_req_o   (mem_req_o),
        .done_o      (done_o),
        .busy_o      (busy)
    );

    lmd_cmd_reg #(
        .CTRL_W (WORD_W),
        .ADDR_W (OFFS_W),
        .FMTW   (FMT_W)
    ) i_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .ctrl_i (ctrl_i),
        .addr_o (mem_addr_o),
        .fmt_o  (fmt_q)
    );

    lmd_extract #(.DW(WORD_W)) i_ext (
        .raw_i   (mem_rdata_i),
        .fmt_i   (fmt_q),
        .value_o (ext_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       result_o <= '0;
        else if (capture) result_o <= ext_val;
    end

    // R10
    addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mem_addr_o) && $stable(fmt_q)));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o) || $rose(done_o));

    // R4
    ubyte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fmt_q == FMT_U8) |-> (result_o[WORD_W-1:8] == '0));

    // R7
    sbyte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fmt_q == FMT_S8) |->
            (result_o[WORD_W-1:8] == {(WORD_W-8){result_o[7]}}));

endmodule

// File: tb/test_lmd_operand_fetch.sv
module test_lmd_operand_fetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] ctrl_i = '0;
    logic        mem_req_o;
    logic [15:0] mem_addr_o;
    logic        mem_valid_i;
    logic [31:0] mem_rdata_i;
    logic [31:0] result_o;
    logic        done_o;

    int checks = 0;
    int bad = 0;
    int reqs = 0;
    int cycles = 0;
    logic [15:0] last_req_addr;

    always #4 clk = ~clk;

    lmd_operand_fetch i_lmd_operand_fetch (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
        .result_o(result_o), .done_o(done_o)
    );

    function automatic logic [7:0] mbyte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] mword(input logic [15:0] a);
        return {mbyte(a + 16'd3), mbyte(a + 16'd2), mbyte(a + 16'd1), mbyte(a)};
    endfunction

    function automatic logic [31:0] expect_val(input logic [31:0] c);
        logic [31:0] w;
        w = mword(c[15:0]);
        case (c[18:16])
            3'd0: return {24'd0, w[7:0]};
            3'd1: return {16'd0, w[15:0]};
            3'd4: return {{24{w[7]}}, w[7:0]};
            3'd5: return {{16{w[15]}}, w[15:0]};
            default: return w;
        endcase
    endfunction

    // behavioural memory, latency 1..4 cycles
    int cnt = 0;
    logic [15:0] rd_addr = '0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= 0;
            mem_valid_i <= 1'b0;
            mem_rdata_i <= '0;
            reqs <= 0;
        end else begin
            mem_valid_i <= 1'b0;
            if (mem_req_o) begin
                cnt <= $urandom_range(1, 4);
                reqs <= reqs + 1;
                rd_addr <= mem_addr_o;
                last_req_addr <= mem_addr_o;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    mem_valid_i <= 1'b1;
                    mem_rdata_i <= mword(rd_addr);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // starts a fetch, waits for done, checks value, request count and address
    task automatic fetch(input logic [31:0] c, input string req);
        int r0;
        int seen;
        r0 = reqs;
        seen = 0;
        @(negedge clk);
        start_i = 1'b1;
        ctrl_i = c;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 20 && seen == 0; i++) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
        check({req, " done seen"}, 32'(seen), 32'd1);
        check(req, result_o, expect_val(c));
        check("R1 addr", {16'd0, last_req_addr}, {16'd0, c[15:0]});
        @(negedge clk);
        check("R2 single done", {31'd0, done_o}, 32'd0);
        check("R2 one request", 32'(reqs - r0), 32'd1);
    endtask

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        check("R11 reset result", result_o, 32'd0);
        check("R11 reset done", {31'd0, done_o}, 32'd0);
        check("R11 reset req", {31'd0, mem_req_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases; high bits above 18 are junk
        fetch({13'h1ABC, 3'd0, 16'h00DA}, "R4 ubyte neg");
        fetch({13'h0000, 3'd0, 16'h0025}, "R4 ubyte pos");
        fetch({13'h0000, 3'd1, 16'h00D9}, "R5 uhalf");
        fetch({13'h0000, 3'd2, 16'h1234}, "R6 word");
        fetch({13'h0000, 3'd3, 16'hFFFE}, "R6 word fmt3 wrap");
        fetch({13'h0000, 3'd4, 16'h00DA}, "R7 sbyte neg");
        fetch({13'h0000, 3'd4, 16'h0025}, "R7 sbyte pos");
        fetch({13'h0000, 3'd5, 16'h00D9}, "R8 shalf neg");
        fetch({13'h0000, 3'd5, 16'hFFFF}, "R8 shalf wrap");
        fetch({13'h0000, 3'd6, 16'h0100}, "R9 fmt6");
        fetch({13'h0000, 3'd7, 16'hFFFD}, "R9 fmt7");

        // R10: starts during a fetch are ignored
        begin
            int r0;
            logic [31:0] c1;
            logic [31:0] c2;
            int extra;
            c1 = {13'd0, 3'd4, 16'h00DA};
            c2 = {13'd0, 3'd2, 16'h4321};
            r0 = reqs;
            extra = 0;
            @(negedge clk);
            start_i = 1'b1; ctrl_i = c1;
            @(negedge clk);
            ctrl_i = c2;
            while (!done_o) @(negedge clk);
            start_i = 1'b0;
            check("R10 result kept", result_o, expect_val(c1));
            check("R10 addr kept", {16'd0, last_req_addr}, {16'd0, c1[15:0]});
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            check("R10 no extra done", 32'(extra), 32'd0);
            check("R10 one request", 32'(reqs - r0), 32'd1);
            check("R11 result held", result_o, expect_val(c1));
        end

        // random stimulus
        for (int n = 0; n < 60; n++) begin
            logic [31:0] c;
            c = $urandom();
            fetch(c, "R3 random");
        end

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule